// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two square matrices of signed integers on a grid of multiply-accumulate cells. Each cell owns one element of the result. The first matrix enters across the left edge, one lane per row, and its values move one cell to the right on every clock. The second matrix enters across the top edge, one lane per column, and its values move one cell down on every clock. Each lane is held back by its own index. Because of that delay, the pair of values that belong together reach the same cell on the same clock.

Operands come from a read port that has one lane for each row of the first matrix and one lane for each column of the second. The block drives an enable and an index on each lane, and the surrounding logic returns the addressed element in the same cycle. Each operand is requested exactly once. After that, it is reused only by passing it from one cell to the next. A start pulse clears the cells and the two tallies and begins the run. A one-cycle done pulse marks the point where every sum is final. The sums then stay on a flat output vector until the next run. One tally counts operand reads and the other counts neighbour-to-neighbour hand-offs.

Top module: `mesh_matmul`

## Requirements
- R1: After reset, busy and done are 0, every result element and both tallies are 0, and no read lane is enabled.
- R2: A start pulse sampled while busy is 0 clears all accumulators and both tallies. It also raises busy from the next cycle.
- R3: Number the cycles of a run m = 0, 1, ... from the first busy cycle. First-matrix lane i is enabled exactly when i ≤ m < i+N, with column index m−i. Second-matrix lane j is enabled exactly when j ≤ m < j+N, with row index m−j. Every operand is therefore read once, and at done the read tally equals 2N² (18 for N = 3).
- R4: Result element (i,j) sits at bits [(i·N+j)·AW +: AW] and equals the signed sum over k of A[i][k]·B[k][j]. Here AW = 2·DW + ceil(log2 N), which is 18 for the defaults.
- R5: Operands are signed DW-bit two's complement values. Sums of N products at the extremes, such as all −128 (giving 49152) or −128 against 127 (giving −48768), come out exact with no wrap.
- R6: Done is high for exactly one cycle, the cycle right after the last of the 3N−1 busy cycles. Busy is 0 while done is high.
- R7: At done, the hop tally equals the number of interior neighbour transfers of valid operands, which is 2N²(N−1) (36 for N = 3).
- R8: A start pulse while busy is 1 has no effect. The run keeps its length and its reads, and its results are still correct.
- R9: While busy is 0 and start is 0, the results and both tallies hold their values.
- R10: A start in the same cycle as done begins a new run at once. The new results do not depend on the previous run's sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run when idle |
| a_rd_en | output | N | Read enable, one lane per first-matrix row |
| a_rd_col | output | N·IW | Column index for each first-matrix lane |
| a_rd_data | input | N·DW | Element returned for each first-matrix lane, same cycle |
| b_rd_en | output | N | Read enable, one lane per second-matrix column |
| b_rd_row | output | N·IW | Row index for each second-matrix lane |
| b_rd_data | input | N·DW | Element returned for each second-matrix lane, same cycle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse once all sums are final |
| result | output | N·N·AW | Flat result vector, element (i,j) at index i·N+j |
| read_count | output | CW | Operand reads in the current or last run |
| hop_count | output | HW | Neighbour hand-offs in the current or last run |

## Verification
The bench checks the read schedule on every clock against the index formula. If the skew were off by one lane, a row would meet the wrong column, the lane pattern would break, and some operand would be read twice or not at all. Extreme operand values check the accumulator width, where a narrow sum would wrap to the wrong sign. A start pulse in the middle of a run checks that a restart cannot occur: a restart would lengthen the run and repeat reads. A start on the done cycle checks that the previous sums are fully cleared: leftover sums would add onto the new result.

// File: rtl/mm_pkg.sv
package mm_pkg;

  typedef enum logic {
    MM_IDLE = 1'b0,
    MM_RUN  = 1'b1
  } mm_state_e;

  function automatic int ceil_log2(input int v);
    int r;
    r = 0;
    while ((1 << r) < v) r++;
    return r;
  endfunction

  // accumulator: full product plus growth for N terms
  function automatic int acc_bits(input int n, input int dw);
    return 2 * dw + ceil_log2(n);
  endfunction

  function automatic int idx_bits(input int n);
    return (n > 1) ? ceil_log2(n) : 1;
  endfunction

  // tick of the final multiply, counting injection as tick 0
  function automatic int last_tick(input int n);
    return 3 * n - 2;
  endfunction

  function automatic int read_total(input int n);
    return 2 * n * n;
  endfunction

  function automatic int hop_total(input int n);
    return 2 * n * n * (n - 1);
  endfunction

endpackage

// File: rtl/mm_ctrl.sv
module mm_ctrl
  import mm_pkg::*;
#(
  parameter int N  = 3,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          run,
  output logic          clr,
  output logic          done,
  output logic [TW-1:0] tick
);
  localparam logic [TW-1:0] LAST = TW'(last_tick(N));

  mm_state_e state;

  assign run = (state == MM_RUN);
  assign clr = start && (state == MM_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= MM_IDLE;
      tick  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        MM_IDLE: begin
          if (start) begin
            state <= MM_RUN;
            tick  <= '0;
          end
        end
        MM_RUN: begin
          if (tick == LAST) begin
            state <= MM_IDLE;
            done  <= 1'b1;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        default: state <= MM_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mm_skew.sv
module mm_skew #(
  parameter int N  = 3,
  parameter int DW = 8,
  parameter int IW = 2,
  parameter int TW = 4
) (
  input  logic            run,
  input  logic [TW-1:0]   tick,
  input  logic [N*DW-1:0] rd_data,
  output logic [N-1:0]    rd_en,
  output logic [N*IW-1:0] rd_idx,
  output logic [N*DW-1:0] op_dat,
  output logic [N-1:0]    op_vld
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    localparam logic [TW:0] LO = (TW+1)'(g);
    localparam logic [TW:0] HI = (TW+1)'(g + N);
    logic [TW:0]   t_ext;
    logic [IW-1:0] off;
    logic          live;

    assign t_ext = {1'b0, tick};
    assign live  = run && (t_ext >= LO) && (t_ext < HI);
    assign off   = IW'(tick - TW'(g));

    assign rd_en[g]              = live;
    assign rd_idx[g*IW +: IW]    = live ? off : '0;
    assign op_vld[g]             = live;
    assign op_dat[g*DW +: DW]    = live ? rd_data[g*DW +: DW] : '0;
  end
endmodule

// File: rtl/mm_pe.sv
module mm_pe #(
  parameter int DW = 8,
  parameter int AW = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic signed [DW-1:0] a_i,
  input  logic                 a_vi,
  input  logic signed [DW-1:0] b_i,
  input  logic                 b_vi,
  output logic signed [DW-1:0] a_o,
  output logic                 a_vo,
  output logic signed [DW-1:0] b_o,
  output logic                 b_vo,
  output logic signed [AW-1:0] acc_o
);
  logic signed [DW-1:0]   a_q, b_q;
  logic                   a_vq, b_vq;
  logic signed [AW-1:0]   acc_q;
  logic signed [2*DW-1:0] prod;
  logic signed [AW-1:0]   prod_x;
  logic                   fire;

  assign fire   = a_vq && b_vq;
  assign prod   = a_q * b_q;
  assign prod_x = AW'(prod);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0; a_vq <= 1'b0; b_vq <= 1'b0; acc_q <= '0;
    end else if (clr) begin
      a_q <= '0; b_q <= '0; a_vq <= 1'b0; b_vq <= 1'b0; acc_q <= '0;
    end else begin
      a_q  <= a_i;
      a_vq <= a_vi;
      b_q  <= b_i;
      b_vq <= b_vi;
      if (fire) acc_q <= acc_q + prod_x;
    end
  end

  assign a_o   = a_q;
  assign a_vo  = a_vq;
  assign b_o   = b_q;
  assign b_vo  = b_vq;
  assign acc_o = acc_q;
endmodule

// File: rtl/mm_tally.sv
module mm_tally #(
  parameter int RV = 6,
  parameter int HV = 12,
  parameter int CW = 5,
  parameter int HW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [RV-1:0] rd_vec,
  input  logic [HV-1:0] hop_vec,
  output logic [CW-1:0] read_count,
  output logic [HW-1:0] hop_count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      read_count <= '0;
      hop_count  <= '0;
    end else if (clr) begin
      read_count <= '0;
      hop_count  <= '0;
    end else begin
      read_count <= read_count + CW'($countones(rd_vec));
      hop_count  <= hop_count  + HW'($countones(hop_vec));
    end
  end
endmodule

// File: rtl/mesh_matmul.sv
module mesh_matmul
  import mm_pkg::*;
#(
  parameter  int N  = 3,
  parameter  int DW = 8,
  localparam int AW = acc_bits(N, DW),
  localparam int IW = idx_bits(N),
  localparam int CW = ceil_log2(read_total(N) + 1),
  localparam int HW = ceil_log2(hop_total(N) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [N-1:0]      a_rd_en,
  output logic [N*IW-1:0]   a_rd_col,
  input  logic [N*DW-1:0]   a_rd_data,
  output logic [N-1:0]      b_rd_en,
  output logic [N*IW-1:0]   b_rd_row,
  input  logic [N*DW-1:0]   b_rd_data,
  output logic              busy,
  output logic              done,
  output logic [N*N*AW-1:0] result,
  output logic [CW-1:0]     read_count,
  output logic [HW-1:0]     hop_count
);
  localparam int TW = ceil_log2(3 * N);
  localparam int RV = 2 * N;
  localparam int HV = 2 * N * (N - 1);

  logic          run, clr;
  logic [TW-1:0] tick;
  logic [N*DW-1:0] a_op, b_op;
  logic [N-1:0]    a_opv, b_opv;
  logic [RV-1:0]   rd_vec;
  logic [HV-1:0]   hop_vec;

  logic signed [DW-1:0] a_lnk [N][N+1];
  logic                 a_vlk [N][N+1];
  logic signed [DW-1:0] b_lnk [N+1][N];
  logic                 b_vlk [N+1][N];

  mm_ctrl #(.N(N), .TW(TW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .run(run), .clr(clr), .done(done), .tick(tick)
  );

  mm_skew #(.N(N), .DW(DW), .IW(IW), .TW(TW)) u_skew_a (
    .run(run), .tick(tick), .rd_data(a_rd_data),
    .rd_en(a_rd_en), .rd_idx(a_rd_col), .op_dat(a_op), .op_vld(a_opv)
  );

  mm_skew #(.N(N), .DW(DW), .IW(IW), .TW(TW)) u_skew_b (
    .run(run), .tick(tick), .rd_data(b_rd_data),
    .rd_en(b_rd_en), .rd_idx(b_rd_row), .op_dat(b_op), .op_vld(b_opv)
  );

  for (genvar e = 0; e < N; e++) begin : g_edge
    assign a_lnk[e][0] = a_op[e*DW +: DW];
    assign a_vlk[e][0] = a_opv[e];
    assign b_lnk[0][e] = b_op[e*DW +: DW];
    assign b_vlk[0][e] = b_opv[e];
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      mm_pe #(.DW(DW), .AW(AW)) u_pe (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .a_i(a_lnk[i][j]),   .a_vi(a_vlk[i][j]),
        .b_i(b_lnk[i][j]),   .b_vi(b_vlk[i][j]),
        .a_o(a_lnk[i][j+1]), .a_vo(a_vlk[i][j+1]),
        .b_o(b_lnk[i+1][j]), .b_vo(b_vlk[i+1][j]),
        .acc_o(result[(i*N+j)*AW +: AW])
      );
      // interior links: rightward hand-offs and downward hand-offs
      if (j > 0) begin : g_hop_a
        assign hop_vec[i*(N-1) + (j-1)] = a_vlk[i][j];
      end
      if (i > 0) begin : g_hop_b
        assign hop_vec[N*(N-1) + (i-1)*N + j] = b_vlk[i][j];
      end
    end
  end

  assign rd_vec = {a_rd_en, b_rd_en};
  assign busy   = run;

  mm_tally #(.RV(RV), .HV(HV), .CW(CW), .HW(HW)) u_tally (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .rd_vec(rd_vec), .hop_vec(hop_vec),
    .read_count(read_count), .hop_count(hop_count)
  );
endmodule

// File: rtl/mesh_matmul_chk.sv
module mesh_matmul_chk
  import mm_pkg::*;
#(
  parameter  int N  = 3,
  parameter  int DW = 8,
  localparam int AW = acc_bits(N, DW),
  localparam int CW = ceil_log2(read_total(N) + 1),
  localparam int HW = ceil_log2(hop_total(N) + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [N*N*AW-1:0] result,
  input logic [CW-1:0]     read_count,
  input logic [HW-1:0]     hop_count
);
  localparam logic [CW-1:0] RD_ALL  = CW'(read_total(N));
  localparam logic [HW-1:0] HOP_ALL = HW'(hop_total(N));

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && read_count == '0 && hop_count == '0));

  p_reads_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (read_count == RD_ALL));

  p_reads_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    read_count <= RD_ALL);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_hops_total_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (hop_count == HOP_ALL));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(result) && $stable(read_count) && $stable(hop_count)));
endmodule

bind mesh_matmul mesh_matmul_chk #(.N(N), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .result(result), .read_count(read_count), .hop_count(hop_count)
);

// File: tb/mesh_matmul_tb.sv
module mesh_matmul_tb;
  import mm_pkg::*;

  localparam int N  = 3;
  localparam int DW = 8;
  localparam int AW = acc_bits(N, DW);
  localparam int IW = idx_bits(N);
  localparam int CW = ceil_log2(read_total(N) + 1);
  localparam int HW = ceil_log2(hop_total(N) + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N-1:0]      a_rd_en, b_rd_en;
  logic [N*IW-1:0]   a_rd_col, b_rd_row;
  logic [N*DW-1:0]   a_rd_data, b_rd_data;
  logic              busy, done;
  logic [N*N*AW-1:0] result;
  logic [CW-1:0]     read_count;
  logic [HW-1:0]     hop_count;

  always #5 clk = ~clk;

  mesh_matmul #(.N(N), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_rd_en(a_rd_en), .a_rd_col(a_rd_col), .a_rd_data(a_rd_data),
    .b_rd_en(b_rd_en), .b_rd_row(b_rd_row), .b_rd_data(b_rd_data),
    .busy(busy), .done(done), .result(result),
    .read_count(read_count), .hop_count(hop_count)
  );

  logic signed [DW-1:0] ma [N][N];
  logic signed [DW-1:0] mb [N][N];

  always_comb begin
    for (int g = 0; g < N; g++) begin
      a_rd_data[g*DW +: DW] = ma[g][a_rd_col[g*IW +: IW]];
      b_rd_data[g*DW +: DW] = mb[b_rd_row[g*IW +: IW]][g];
    end
  end

  int n_checks = 0;
  int n_fail   = 0;
  logic [N*N*AW-1:0] exp_q [$];
  logic [N*N*AW-1:0] last_exp;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // ---------------- monitor: schedule, reads, results ----------------
  int m = 0;
  int sched_bad = 0;
  int hits_a [N][N];
  int hits_b [N][N];

  initial begin
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin hits_a[r][c] = 0; hits_b[r][c] = 0; end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      for (int g = 0; g < N; g++) begin
        bit want;
        want = busy && (m >= g) && (m < g + N);
        if (a_rd_en[g] !== want || b_rd_en[g] !== want) sched_bad++;
        if (want && (int'(a_rd_col[g*IW +: IW]) != m - g || int'(b_rd_row[g*IW +: IW]) != m - g))
          sched_bad++;
        if (a_rd_en[g]) hits_a[g][a_rd_col[g*IW +: IW]]++;
        if (b_rd_en[g]) hits_b[b_rd_row[g*IW +: IW]][g]++;
      end
      if (busy) m++;
      if (done) begin
        logic [N*N*AW-1:0] e;
        int once_bad;
        check(m == 3*N - 1, "R6", "busy cycles before done", m, 3*N - 1);
        check(busy == 1'b0, "R6", "busy during done", busy, 0);
        check(sched_bad == 0, "R3", "read lane schedule mismatches", sched_bad, 0);
        once_bad = 0;
        for (int r = 0; r < N; r++)
          for (int c = 0; c < N; c++) begin
            if (hits_a[r][c] != 1) once_bad++;
            if (hits_b[r][c] != 1) once_bad++;
            hits_a[r][c] = 0; hits_b[r][c] = 0;
          end
        check(once_bad == 0, "R3", "operands not read exactly once", once_bad, 0);
        check(read_count == CW'(read_total(N)), "R3", "read tally", read_count, read_total(N));
        check(hop_count == HW'(hop_total(N)), "R7", "hop tally", hop_count, hop_total(N));
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "unexpected done, empty scoreboard", 1, 0);
        end else begin
          e = exp_q.pop_front();
          for (int k = 0; k < N*N; k++)
            check(result[k*AW +: AW] == e[k*AW +: AW], "R4", $sformatf("element %0d", k),
                  longint'($signed(result[k*AW +: AW])), longint'($signed(e[k*AW +: AW])));
        end
        m = 0;
        sched_bad = 0;
      end
    end
  end

  // ---------------- driver ----------------
  task automatic load(input int sa, input int sb, input int mode);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        case (mode)
          1: begin ma[r][c] = -8'sd128; mb[r][c] = -8'sd128; end
          2: begin ma[r][c] = -8'sd128; mb[r][c] = 8'sd127; end
          3: begin ma[r][c] = (r == c) ? 8'sd1 : 8'sd0; mb[r][c] = DW'(r*5 - c*9 + sb); end
          default: begin ma[r][c] = DW'(r*7 - c*13 + sa); mb[r][c] = DW'(c*11 - r*3 - sb); end
        endcase
      end
  endtask

  task automatic push_exp();
    logic [N*N*AW-1:0] e;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        int s;
        s = 0;
        for (int k = 0; k < N; k++) s += int'(ma[r][k]) * int'(mb[k][c]);
        e[(r*N+c)*AW +: AW] = AW'(s);
      end
    exp_q.push_back(e);
    last_exp = e;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic run_one(input int sa, input int sb, input int mode);
    @(negedge clk);
    load(sa, sb, mode);
    push_exp();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    load(0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(busy == 1'b0 && done == 1'b0, "R1", "busy/done after reset", {busy, done}, 0);
    check(result == '0, "R1", "result after reset", (result == '0) ? 0 : 1, 0);
    check(read_count == '0 && hop_count == '0, "R1", "tallies after reset", read_count + hop_count, 0);
    check(a_rd_en == '0 && b_rd_en == '0, "R1", "read lanes idle", {a_rd_en, b_rd_en}, 0);

    // R4: general signed patterns, identity
    run_one(3, 5, 0);
    run_one(-40, 17, 0);
    run_one(0, 22, 3);
    // R5: extremes
    run_one(0, 0, 1);
    run_one(0, 0, 2);

    // R8: stray start in mid-run
    @(negedge clk);
    load(9, -6, 0);
    push_exp();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R8", "still busy after stray start", busy, 1);
    wait_done();

    // R10: start on the done cycle, new matrices
    load(-70, 33, 0);
    push_exp();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10", "back-to-back run accepted", busy, 1);
    wait_done();

    // R9: hold after done
    repeat (4) @(negedge clk);
    check(result == last_exp, "R9", "result held after done", (result == last_exp) ? 1 : 0, 1);
    check(read_count == CW'(read_total(N)), "R9", "read tally held", read_count, read_total(N));
    check(hop_count == HW'(hop_total(N)), "R9", "hop tally held", hop_count, hop_total(N));
    check(done == 1'b0 && busy == 1'b0, "R9", "idle after hold", {busy, done}, 0);

    // R2: start clears accumulators and tallies
    load(1, 1, 0);
    push_exp();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", "busy after start", busy, 1);
    check(read_count == '0 && hop_count == '0, "R2", "tallies cleared", read_count + hop_count, 0);
    check(result == '0, "R2", "accumulators cleared", (result == '0) ? 0 : 1, 0);
    wait_done();
    @(negedge clk);
    check(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule